// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator

This block generates the local oscillator pair for a real-to-complex downconverter. Each accepted input cycle produces one cosine sample and one negated sine sample. The two outputs go to the in-phase and quadrature mixers, so the pair forms cos − j·sin at a frequency set by a tuning word. A phase accumulator advances by the tuning word only on cycles where the input-valid strobe is high. The tone therefore stays phase-locked to the sample stream when upstream flow control inserts gaps.

The upper bits of the accumulator index a sine table that holds one quarter of a period. The table is computed at elaboration, and sign and address-mirror logic rebuild the other three quadrants from it. Table samples sit half a step off the quadrant boundaries, so mirroring the address is an exact bitwise inversion. The output-valid flag stays low until the three-stage pipeline has filled after reset. From then on it repeats the input-valid strobe three cycles later, with no gaps of its own.

With a 120 MS/s sample stream and the default 32-bit accumulator, the tuning word for a tone at f Hz is round(f / 120e6 · 2^32). Words with the top bit set give negative frequencies.

Top module: `quad_nco`

## Requirements
- R1: The n-th accepted sample after reset uses phase index k, the top PHASE_W (default 10) bits of the sum, modulo 2^ACC_W, of the tuning words presented on all earlier accepted cycles. The accumulator does not move on cycles with in_valid low.
- R2: For phase index k, cos_out equals round(A·cos(2π(k+0.5)/2^PHASE_W)), with A = 2^(OUT_W−1) − 1. The result is within one LSB of that value.
- R3: For phase index k, nsin_out equals −round(A·sin(2π(k+0.5)/2^PHASE_W)), within one LSB.
- R4: Both outputs are OUT_W-bit (default 20) two's-complement values with one integer bit, so they span −1 to just under +1. Neither output ever takes the most negative code.
- R5: out_valid after clock edge t equals in_valid sampled at edge t−2, which is a latency of three edges. out_valid is low for the first three edges after reset, whatever in_valid does.
- R6: When out_valid is low, cos_out and nsin_out keep the values they held on the previous cycle.
- R7: A synchronous reset (rst high at an edge) clears the accumulator to phase zero, drops out_valid, sets both outputs to zero and discards samples in flight. The first sample accepted after reset uses phase index 0.
- R8: A tuning word of 2^(ACC_W−2), which is a quarter of the sample rate, gives output sequences that repeat every four accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; advances the accumulator |
| tune_word | input | ACC_W | Phase increment per accepted sample |
| out_valid | output | 1 | Output sample valid |
| cos_out | output | OUT_W | Cosine sample, signed |
| nsin_out | output | OUT_W | Negated sine sample, signed |

## Verification
Two things can fall on the same clock edge: a reset, and an accepted sample with a new tuning word. When they coincide, the reset must win. No sample from before the reset may come out later, and the accumulator must restart from zero rather than from zero plus the word. The bench provokes this with random resets while in_valid is held high, and with directed resets in the middle of a stream. It then checks the valid delay, the dropped samples and the phase of the first new sample against its own phase model and trigonometric reference.

// File: rtl/quad_nco.sv
module quad_nco #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 10,
  parameter int OUT_W   = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [ACC_W-1:0]        tune_word,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] cos_out,
  output logic signed [OUT_W-1:0] nsin_out
);
  localparam int QA_W   = PHASE_W - 2;
  localparam int QDEPTH = 1 << QA_W;
  localparam int MAG_W  = OUT_W - 1;
  localparam real AMP   = real'((64'd1 << MAG_W) - 64'd1);
  localparam real TWO_PI = 6.283185307179586;
  localparam logic [PHASE_W-1:0] QTR = PHASE_W'(QDEPTH);

  function automatic logic [MAG_W-1:0] qval(input int a);
    real x;
    x = $sin(TWO_PI * (real'(a) + 0.5) / real'(4 * QDEPTH)) * AMP;
    return MAG_W'($rtoi(x + 0.5));
  endfunction

  logic [MAG_W-1:0] qrom [QDEPTH];
  for (genvar i = 0; i < QDEPTH; i++) begin : g_rom
    assign qrom[i] = qval(i);
  end

  logic [ACC_W-1:0]   acc;
  logic [PHASE_W-1:0] ph_s, ph_c;
  logic               v0, v1;
  logic [1:0]         q_s, q_c;
  logic [MAG_W-1:0]   m_s, m_c;

  wire [QA_W-1:0] a_s = ph_s[PHASE_W-2] ? ~ph_s[QA_W-1:0] : ph_s[QA_W-1:0];
  wire [QA_W-1:0] a_c = ph_c[PHASE_W-2] ? ~ph_c[QA_W-1:0] : ph_c[QA_W-1:0];

  wire signed [OUT_W-1:0] mag_s = $signed({1'b0, m_s});
  wire signed [OUT_W-1:0] mag_c = $signed({1'b0, m_c});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      ph_s <= '0;
      ph_c <= '0;
      v0   <= 1'b0;
    end else begin
      v0 <= in_valid;
      if (in_valid) begin
        ph_s <= acc[ACC_W-1 -: PHASE_W];
        ph_c <= acc[ACC_W-1 -: PHASE_W] + QTR;
        acc  <= acc + tune_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1  <= 1'b0;
      q_s <= '0;
      q_c <= '0;
      m_s <= '0;
      m_c <= '0;
    end else begin
      v1 <= v0;
      if (v0) begin
        q_s <= ph_s[PHASE_W-1 -: 2];
        q_c <= ph_c[PHASE_W-1 -: 2];
        m_s <= qrom[a_s];
        m_c <= qrom[a_c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cos_out   <= '0;
      nsin_out  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        cos_out  <= q_c[1] ? -mag_c : mag_c;
        nsin_out <= q_s[1] ? mag_s : -mag_s;
      end
    end
  end
endmodule

module quad_nco_chk #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic [ACC_W-1:0]        acc,
  input logic signed [OUT_W-1:0] cos_out,
  input logic signed [OUT_W-1:0] nsin_out
);
  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc)); // R1
  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
    (cos_out != MOST_NEG) && (nsin_out != MOST_NEG)); // R4
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R5
  AST_VALID_EARLY_LOW: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd3) |-> !out_valid); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((since_rst != 2'd0) && !out_valid) |-> ($stable(cos_out) && $stable(nsin_out))); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd0) |-> (acc == '0 && !out_valid && cos_out == '0 && nsin_out == '0)); // R7
endmodule

bind quad_nco quad_nco_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .acc(acc), .cos_out(cos_out), .nsin_out(nsin_out)
);

// File: tb/tb_quad_nco.sv
`timescale 1ns/1ps
module tb_quad_nco;
  localparam int ACC_W = 32;
  localparam int PHASE_W = 10;
  localparam int OUT_W = 20;
  localparam real AMP = 524287.0;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [ACC_W-1:0] tune_word = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] cos_out, nsin_out;

  quad_nco #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .tune_word(tune_word),
    .out_valid(out_valid), .cos_out(cos_out), .nsin_out(nsin_out));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [ACC_W-1:0] macc = '0;
  logic [2:0] hist = '0;
  int eq_c[$], eq_s[$], got_c[$], got_s[$];
  bit first_after_rst = 1'b0;
  logic signed [OUT_W-1:0] last_c = '0, last_s = '0;

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int ref_cos(input int k);
    return rnd(AMP * $cos(TWO_PI * (real'(k) + 0.5) / 1024.0));
  endfunction

  function automatic int ref_nsin(input int k);
    return -rnd(AMP * $sin(TWO_PI * (real'(k) + 0.5) / 1024.0));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit near(input int a, input int b);
    return (a - b <= 1) && (b - a <= 1);
  endfunction

  task automatic check_out();
    int ec, es;
    chk(out_valid == hist[2], "R5 out_valid", int'(out_valid), int'(hist[2]));
    if (out_valid) begin
      if (eq_c.size() == 0) begin
        chk(1'b0, "R5 unexpected sample", 1, 0);
      end else begin
        ec = eq_c.pop_front();
        es = eq_s.pop_front();
        if (first_after_rst)
          chk(near(int'(cos_out), ref_cos(0)), "R7 first sample phase zero", int'(cos_out), ref_cos(0));
        first_after_rst = 1'b0;
        chk(near(int'(cos_out), ec), "R1,R2 cos_out", int'(cos_out), ec);
        chk(near(int'(nsin_out), es), "R1,R3 nsin_out", int'(nsin_out), es);
        chk(cos_out != -20'sd524288 && nsin_out != -20'sd524288, "R4 most negative code",
            int'(cos_out), -524287);
        got_c.push_back(int'(cos_out));
        got_s.push_back(int'(nsin_out));
      end
    end else begin
      chk(cos_out == last_c && nsin_out == last_s, "R6 hold while idle", int'(cos_out), int'(last_c));
    end
    last_c = cos_out;
    last_s = nsin_out;
  endtask

  task automatic cyc(input bit v, input logic [ACC_W-1:0] tw, input bit r);
    rst = r;
    in_valid = v;
    tune_word = tw;
    @(posedge clk);
    if (r) begin
      macc = '0;
      hist = '0;
      eq_c.delete(); eq_s.delete(); got_c.delete(); got_s.delete();
      first_after_rst = 1'b1;
    end else begin
      hist = {hist[1:0], v};
      if (v) begin
        eq_c.push_back(ref_cos(int'(macc[ACC_W-1 -: PHASE_W])));
        eq_s.push_back(ref_nsin(int'(macc[ACC_W-1 -: PHASE_W])));
        macc = macc + tw;
      end
    end
    @(negedge clk);
    if (r) begin
      chk(!out_valid && cos_out == 0 && nsin_out == 0, "R7 reset state", int'(cos_out), 0);
      last_c = cos_out;
      last_s = nsin_out;
    end else begin
      check_out();
    end
  endtask

  initial begin
    logic [ACC_W-1:0] tw;
    @(negedge clk);
    cyc(0, '0, 1);
    cyc(0, '0, 1);
    // R1: zero tuning word holds the phase
    for (int i = 0; i < 6; i++) cyc(1, '0, 0);
    for (int i = 0; i < 4; i++) cyc(0, '0, 0);
    // R8: quarter-rate tone
    cyc(0, '0, 1);
    for (int i = 0; i < 8; i++) cyc(1, 32'h4000_0000, 0);
    for (int i = 0; i < 4; i++) cyc(0, '0, 0);
    chk(got_c.size() == 8, "R8 sample count", got_c.size(), 8);
    for (int i = 0; i < 4 && got_c.size() == 8; i++) begin
      chk(got_c[i] == got_c[i+4], "R8 cos period four", got_c[i+4], got_c[i]);
      chk(got_s[i] == got_s[i+4], "R8 nsin period four", got_s[i+4], got_s[i]);
    end
    // gaps in the valid stream, and a negative frequency
    for (int i = 0; i < 20; i++) cyc(i % 3 != 0, 32'h0123_4567, 0);
    for (int i = 0; i < 12; i++) cyc(1, 32'hFF00_0000, 0);
    // R5/R7: reset in the middle of a continuous stream
    cyc(1, 32'h0555_0000, 1);
    for (int i = 0; i < 10; i++) cyc(1, 32'h0555_0000, 0);
    // constrained random
    void'($urandom(32'd20241));
    tw = $urandom;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(49) == 0) tw = $urandom;
      if ($urandom_range(199) == 0) tw = 32'hFFFF_FFFF;
      cyc($urandom_range(3) != 0, tw, $urandom_range(399) == 0);
    end
    for (int i = 0; i < 5; i++) cyc(0, '0, 0);
    chk(eq_c.size() == 0, "R5 all samples delivered", eq_c.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule